// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Modes

This block turns parallel characters into an asynchronous serial stream. A single holding buffer sits in front of a frame shifter. The shifter is paced by a clock enable that pulses sixteen times per bit, so every bit cell lasts sixteen enable pulses. A character is built from its configuration at the moment it leaves the buffer:

- a low start bit;
- five to eight data bits, least significant first;
- an optional even or odd parity bit;
- one, one and a half, or two high stop bits.

A clear-to-send input decides whether a new character may begin. A character already on the line always finishes. Two flags report progress: one says the holding buffer is empty, the other says the whole transmit path is empty.

A two-bit line mode sets how the output pin is used:

- **Normal**: ordinary transmission.
- **Break**: every bit of each frame, stop bits included, is sent as zero.
- **Echo**: the serial input pin is wired straight through to the serial output, and no character is started.
- **Loop**: frames go to a receiver-side loopback output, and the serial output stays high.

The baud generator, the receiver and the register file are outside the block. They connect through the tick input, the loopback output and the configuration inputs.

Top module: `uart_tx_lm`

## Requirements
- R1: Word length `word_len_i` encodes 00=5, 01=6, 10=7, 11=8 data bits. The frame is a low start bit followed by the data bits, bit 0 first. Buffer bits above the word length have no effect on the line.
- R2: With `stop_sel_i`=0 one high stop cell is sent. With `stop_sel_i`=1 a 5-bit word gets one and a half stop cells (16+8 ticks), and 6, 7 or 8-bit words get two (16+16 ticks).
- R3: `par_sel_i` encodes 01=even parity (data ones plus parity bit is even), 10=odd parity, 00 or 11=no parity bit. The parity bit follows the last data bit.
- R4: `tx_o` is high while reset is asserted and whenever no frame cell is being sent.
- R5: While `cts_i` is low, no new character starts outside loop mode. A character already in its start, data or stop cells completes. A buffered character waits and starts once `cts_i` returns high.
- R6: In break mode (`line_mode_i`=01) every cell of the frame, start, data, parity and stop, is low. Cell count and durations are unchanged.
- R7: In echo mode (`line_mode_i`=10) `tx_o` follows `rx_pin_i` combinationally. No buffered character is started, and the buffer stays full.
- R8: In loop mode (`line_mode_i`=11) `tx_o` stays high. The frame appears on `rx_loop_o`, and `cts_i` is ignored. In all other modes `rx_loop_o` follows `rx_pin_i`.
- R9: `buf_empty_o` is high after reset, falls in the cycle after a write, and rises in the cycle after the buffer moves into the shifter. With an idle shifter the move happens on the first tick after the write, and the start cell begins after the fifth tick.
- R10: `tx_done_o` is high exactly when the buffer is empty and no character is in lead-in or on the line. It is high after reset.
- R11: A character already in the buffer at the 12th tick of a 16-tick final stop cell (4th tick of a half cell) is taken then. Its start cell follows the last stop cell with no gap. A character written later goes through the idle lead-in instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Enable pulse at 16x the bit rate |
| wr_i | input | 1 | Write strobe for the holding buffer |
| wr_data_i | input | 8 | Character to send |
| word_len_i | input | 2 | Data bit count select |
| stop_sel_i | input | 1 | Stop length select |
| par_sel_i | input | 2 | Transmit parity select |
| line_mode_i | input | 2 | 00 normal, 01 break, 10 echo, 11 loop |
| cts_i | input | 1 | Clear to send, high = true |
| rx_pin_i | input | 1 | Serial input pin, used by echo and for the receiver path |
| tx_o | output | 1 | Serial output pin |
| rx_loop_o | output | 1 | Serial stream toward the receiver |
| buf_empty_o | output | 1 | Holding buffer empty |
| tx_done_o | output | 1 | Buffer and shifter both empty |

## Verification
Characters are sent at every word length with mixed bit patterns, at every parity and stop selection. All-ones data with a short word length shows that unused upper bits are ignored. Paired writes are placed before and after the twelfth tick of the final stop cell, which separates the seamless handoff from the idle lead-in path. Clear-to-send is dropped both while the shifter is idle and in the middle of a character, which separates "do not start" from "abort". Break, echo and loop are each run with a full buffer, so that a mode which wrongly starts, drops or routes a character shows up on the pins or on the empty flag.

// File: rtl/uart_tx_lm_pkg.sv
package uart_tx_lm_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_BREAK  = 2'b01,
    MODE_ECHO   = 2'b10,
    MODE_LOOP   = 2'b11
  } line_mode_e;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LEAD = 2'b01,
    ST_SEND = 2'b10
  } shift_state_e;
endpackage

// File: rtl/uart_tx_hold_buf.sv
module uart_tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      full_o <= 1'b1;
      data_o <= data_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end

  assert_wr_fills_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);
  assert_take_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !wr_i) |=> !full_o);
endmodule

// File: rtl/uart_tx_frame_build.sv
module uart_tx_frame_build
  import uart_tx_lm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CELL_W  = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [1:0]         word_len_i,
  input  logic               stop_sel_i,
  input  logic [1:0]         par_sel_i,
  input  logic               brk_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CELL_W-1:0]  ncell_o,
  output logic               half_o
);
  localparam int MIN_W = DATA_W - 3;

  logic [DATA_W-1:0] keep;
  logic [DATA_W:0]   dext;
  logic              par_en, par_bit;

  // one mask bit per data position, active below the selected length
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign keep[g] = (g < MIN_W + int'(word_len_i));
  end

  assign dext    = {1'b0, data_i & keep};
  assign par_en  = (par_sel_i == PAR_EVEN) || (par_sel_i == PAR_ODD);
  assign par_bit = (par_sel_i == PAR_EVEN) ? ^(data_i & keep) : ~^(data_i & keep);
  assign half_o  = stop_sel_i && (word_len_i == 2'b00);

  always_comb begin
    int dlen;
    dlen    = MIN_W + int'(word_len_i);
    frame_o = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i <= DATA_W; i++) begin
      if (i < dlen) frame_o[1+i] = dext[i];
      else if (i == dlen && par_en) frame_o[1+i] = par_bit;
    end
    if (brk_i) frame_o = '0;
    ncell_o = CELL_W'(1 + dlen + (par_en ? 1 : 0) + (stop_sel_i ? 2 : 1));
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_lm_pkg::*;
#(
  parameter int TICKS   = 16,
  parameter int LEAD    = 4,
  parameter int HANDOFF = 4,
  parameter int FRAME_W = 12,
  parameter int CELL_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               ready_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CELL_W-1:0]  ncell_i,
  input  logic               half_i,
  output logic               take_o,
  output logic               bit_o,
  output logic               busy_o
);
  localparam int TW   = $clog2(TICKS);
  localparam int HALF = TICKS / 2;

  shift_state_e       state_q;
  logic [FRAME_W-1:0] frame_q, stg_frame_q;
  logic [CELL_W-1:0]  ncell_q, stg_ncell_q;
  logic               half_q, stg_half_q, pend_q;
  logic [TW-1:0]      tcnt_q, last_t, handoff_t;
  logic               last_cell;

  assign last_cell = (ncell_q == CELL_W'(1));
  assign last_t    = (last_cell && half_q) ? TW'(HALF - 1) : TW'(TICKS - 1);
  assign handoff_t = last_t - TW'(HANDOFF);

  // idle start, or early hand-off inside the final stop cell
  assign take_o = tick_i && ready_i &&
                  ((state_q == ST_IDLE) ||
                   (state_q == ST_SEND && last_cell && tcnt_q == handoff_t && !pend_q));
  assign bit_o  = (state_q == ST_SEND) ? frame_q[0] : 1'b1;
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      frame_q     <= '1;
      ncell_q     <= '0;
      half_q      <= 1'b0;
      tcnt_q      <= '0;
      pend_q      <= 1'b0;
      stg_frame_q <= '1;
      stg_ncell_q <= '0;
      stg_half_q  <= 1'b0;
    end else if (tick_i) begin
      case (state_q)
        ST_IDLE: if (take_o) begin
          frame_q <= frame_i;
          ncell_q <= ncell_i;
          half_q  <= half_i;
          tcnt_q  <= '0;
          state_q <= ST_LEAD;
        end
        ST_LEAD: begin
          if (tcnt_q == TW'(LEAD - 1)) begin
            tcnt_q  <= '0;
            state_q <= ST_SEND;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        ST_SEND: begin
          if (take_o) begin
            pend_q      <= 1'b1;
            stg_frame_q <= frame_i;
            stg_ncell_q <= ncell_i;
            stg_half_q  <= half_i;
          end
          if (tcnt_q == last_t) begin
            tcnt_q <= '0;
            if (last_cell) begin
              if (pend_q) begin
                frame_q <= stg_frame_q;
                ncell_q <= stg_ncell_q;
                half_q  <= stg_half_q;
                pend_q  <= 1'b0;
              end else state_q <= ST_IDLE;
            end else begin
              frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
              ncell_q <= ncell_q - 1'b1;
            end
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_start_bit_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEAD && tick_i && tcnt_q == TW'(LEAD - 1)) |=> !bit_o);
  assert_idle_needs_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !tick_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/uart_tx_lm.sv
module uart_tx_lm
  import uart_tx_lm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TICKS   = 16,
  parameter int LEAD    = 4,
  parameter int HANDOFF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        word_len_i,
  input  logic              stop_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic [1:0]        line_mode_i,
  input  logic              cts_i,
  input  logic              rx_pin_i,
  output logic              tx_o,
  output logic              rx_loop_o,
  output logic              buf_empty_o,
  output logic              tx_done_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CELL_W  = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  buf_data;
  logic               buf_full, take, ready, busy, line_bit, half;
  logic [FRAME_W-1:0] frame;
  logic [CELL_W-1:0]  ncell;
  logic               is_loop, is_echo;

  assign is_loop = (line_mode_i == MODE_LOOP);
  assign is_echo = (line_mode_i == MODE_ECHO);
  assign ready   = buf_full && !is_echo && (cts_i || is_loop);

  uart_tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .wr_i, .data_i(wr_data_i), .take_i(take),
    .data_o(buf_data), .full_o(buf_full)
  );

  uart_tx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CELL_W(CELL_W)) u_build (
    .data_i(buf_data), .word_len_i, .stop_sel_i, .par_sel_i,
    .brk_i(line_mode_i == MODE_BREAK),
    .frame_o(frame), .ncell_o(ncell), .half_o(half)
  );

  uart_tx_shifter #(.TICKS(TICKS), .LEAD(LEAD), .HANDOFF(HANDOFF),
                    .FRAME_W(FRAME_W), .CELL_W(CELL_W)) u_shift (
    .clk_i, .rst_ni, .tick_i, .ready_i(ready), .frame_i(frame), .ncell_i(ncell),
    .half_i(half), .take_o(take), .bit_o(line_bit), .busy_o(busy)
  );

  assign tx_o        = is_echo ? rx_pin_i : (is_loop ? 1'b1 : line_bit);
  assign rx_loop_o   = is_loop ? line_bit : rx_pin_i;
  assign buf_empty_o = !buf_full;
  assign tx_done_o   = !buf_full && !busy;

  assert_cts_blocks_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cts_i && !is_loop && !busy) |=> !busy);
  assert_echo_no_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_echo && !busy) |=> !busy);
  assert_handoff_keeps_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && busy) |=> busy);
endmodule

// File: tb/uart_tx_lm_tb_top.sv
module uart_tx_lm_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0, stop_sel = 1'b0, cts = 1'b1, rx_pin = 1'b1;
  logic [7:0] wdata = '0;
  logic [1:0] wlen = 2'b11, par = 2'b00, mode = 2'b00;
  logic tx, rx_loop, buf_empty, tx_done;

  int n_checks = 0, n_err = 0, cyc = 0, tdiv = 0;
  string cur_req = "R4";

  always #10 clk = ~clk;

  uart_tx_lm dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .word_len_i(wlen), .stop_sel_i(stop_sel), .par_sel_i(par), .line_mode_i(mode),
    .cts_i(cts), .rx_pin_i(rx_pin), .tx_o(tx), .rx_loop_o(rx_loop),
    .buf_empty_o(buf_empty), .tx_done_o(tx_done)
  );

  // behavioural reference: phase 0 idle, 1 lead-in, 2 sending
  int   m_phase = 0, m_cnt = 0;
  bit   m_full = 0, m_pend = 0;
  logic [7:0] m_data = '0;
  int   cur_b[$], cur_d[$], nxt_b[$], nxt_d[$];

  function automatic void build_next();
    int n, ones;
    bit brk;
    n = 5 + int'(wlen);
    brk = (mode == 2'b01);
    ones = 0;
    nxt_b.delete(); nxt_d.delete();
    nxt_b.push_back(0);
    for (int i = 0; i < n; i++) begin
      nxt_b.push_back(int'(m_data[i]));
      ones += int'(m_data[i]);
    end
    if (par == 2'b01) nxt_b.push_back(ones % 2);
    if (par == 2'b10) nxt_b.push_back(1 - ones % 2);
    nxt_b.push_back(1);
    if (stop_sel) nxt_b.push_back(1);
    foreach (nxt_b[k]) nxt_d.push_back(16);
    if (stop_sel && wlen == 2'b00) nxt_d[nxt_d.size()-1] = 8;
    if (brk) foreach (nxt_b[k]) nxt_b[k] = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_full = 0; m_pend = 0;
      cur_b.delete(); cur_d.delete();
    end else begin
      bit ok, took;
      ok = m_full && mode != 2'b10 && (cts || mode == 2'b11);
      took = 0;
      if (tick) begin
        if (m_phase == 0) begin
          if (ok) begin
            build_next(); cur_b = nxt_b; cur_d = nxt_d;
            took = 1; m_phase = 1; m_cnt = 0;
          end
        end else if (m_phase == 1) begin
          m_cnt++;
          if (m_cnt == 4) begin m_phase = 2; m_cnt = 0; end
        end else begin
          m_cnt++;
          if (cur_b.size() == 1 && m_cnt == cur_d[0] - 4 && ok && !m_pend) begin
            build_next(); m_pend = 1; took = 1;
          end
          if (m_cnt == cur_d[0]) begin
            void'(cur_b.pop_front()); void'(cur_d.pop_front());
            m_cnt = 0;
            if (cur_b.size() == 0) begin
              if (m_pend) begin cur_b = nxt_b; cur_d = nxt_d; m_pend = 0; end
              else m_phase = 0;
            end
          end
        end
      end
      if (wr) begin m_full = 1; m_data = wdata; end
      else if (took) m_full = 0;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every clock, well after inputs settle
  always @(negedge clk) begin
    #5;
    begin
      logic line, e_tx, e_loop;
      line   = (rst_n && m_phase == 2) ? logic'(cur_b[0][0]) : 1'b1;
      e_tx   = (mode == 2'b10) ? rx_pin : ((mode == 2'b11) ? 1'b1 : line);
      e_loop = (mode == 2'b11) ? line : rx_pin;
      chk(cur_req, "tx_o", tx, e_tx);
      chk(cur_req, "rx_loop_o", rx_loop, e_loop);
      chk("R9", "buf_empty_o", buf_empty, logic'(!m_full));
      chk("R10", "tx_done_o", tx_done, logic'(!m_full && m_phase == 0));
    end
  end

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 3);
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic write(logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(m_phase == 0 && !m_full));
  endtask

  task automatic send(logic [7:0] d);
    write(d); wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #6;
    chk("R4", "tx_o in reset", tx, 1'b1);
    chk("R9", "buf_empty_o in reset", buf_empty, 1'b1);
    chk("R10", "tx_done_o in reset", tx_done, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    repeat (8) @(negedge clk);

    cur_req = "R1"; send(8'hA5);
    cur_req = "R3"; wlen = 2'b11; par = 2'b01; send(8'h3C);
    par = 2'b10; send(8'h3C); send(8'h3D);
    cur_req = "R1"; wlen = 2'b00; par = 2'b10; send(8'hFF);
    wlen = 2'b01; par = 2'b00; send(8'hC9);
    wlen = 2'b10; par = 2'b01; send(8'h55);
    cur_req = "R2"; stop_sel = 1'b1; wlen = 2'b00; par = 2'b00; send(8'h0A);
    wlen = 2'b11; send(8'h81);
    wlen = 2'b00; par = 2'b01; write(8'h13);
    do @(negedge clk); while (!buf_empty);
    write(8'h1C); wait_idle();

    cur_req = "R11"; stop_sel = 1'b0; wlen = 2'b11; par = 2'b00;
    write(8'h12);
    #6 chk("R9", "buf_empty_o after write", buf_empty, 1'b0);
    do @(negedge clk); while (!buf_empty);
    write(8'h34); wait_idle();
    write(8'h56);
    do @(negedge clk); while (!(m_phase == 2 && cur_b.size() == 1 && m_cnt >= 13));
    write(8'h78); wait_idle();

    cur_req = "R5"; cts = 1'b0; write(8'h99);
    repeat (200) @(negedge clk);
    #6 chk("R5", "buf_empty_o with cts low", buf_empty, 1'b0);
    chk("R5", "tx_o with cts low", tx, 1'b1);
    cts = 1'b1; wait_idle();
    write(8'h00);
    do @(negedge clk); while (m_phase != 2);
    repeat (192) @(negedge clk);
    cts = 1'b0; write(8'hEE);
    repeat (800) @(negedge clk);
    #6 chk("R5", "buf_empty_o after finished char", buf_empty, 1'b0);
    chk("R5", "tx_o idle after finished char", tx, 1'b1);
    cts = 1'b1; wait_idle();

    cur_req = "R6"; mode = 2'b01; send(8'hFF); mode = 2'b00;

    cur_req = "R7"; mode = 2'b10; write(8'h3B);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); rx_pin = (i % 3 == 0) ? 1'b0 : 1'b1;
    end
    #6 chk("R7", "buf_empty_o in echo", buf_empty, 1'b0);
    @(negedge clk); rx_pin = 1'b1; mode = 2'b00;
    cur_req = "R1"; wait_idle();

    cur_req = "R8"; mode = 2'b11; cts = 1'b0; send(8'hC3);
    @(negedge clk); mode = 2'b00; cts = 1'b1;

    cur_req = "R4"; repeat (40) @(negedge clk);
    #6 chk("R4", "tx_o idle", tx, 1'b1);
    chk("R10", "tx_done_o idle", tx_done, 1'b1);
    finish_run();
  end
endmodule